// File: doc/BRIEF.md
# Subset Instruction Decoder and Execute Unit

This block sits between register read and memory access in a simple pipeline. It receives one 32-bit instruction word and the two operand values already read from the register file. From these it produces the register indices to read and write, a register write enable, memory read and write strobes with a byte or word size flag, and one 32-bit arithmetic result. The block has no clock and no state.

Six instructions are recognised. Register-format add and subtract combine the two operand values. Four immediate-format memory instructions reuse the same adder to form an effective address: the base operand plus a sign-extended 16-bit offset. Any other encoding raises an illegal flag, and the block then holds every strobe low so that nothing downstream changes state.

Top module: `subset_exec_unit`

## Requirements
- R1: Source index `rs_idx_o` is always instruction bits [25:21] and `rt_idx_o` is always bits [20:16], for every encoding, legal or not.
- R2: Opcode 0 (bits [31:26]) with function code 32 (bits [5:0]) and shift field 0 (bits [10:6]) is add: `result_o` = rs value + rt value modulo 2^32, `reg_we_o`=1, `wr_idx_o` = bits [15:11], both memory strobes low.
- R3: Opcode 0 with function code 34 and shift field 0 is subtract: `result_o` = rs value - rt value modulo 2^32, `reg_we_o`=1, `wr_idx_o` = bits [15:11], memory strobes low.
- R4: Opcode 35 (word load): `mem_rd_o`=1, `mem_wr_o`=0, `mem_byte_o`=0, `reg_we_o`=1, `wr_idx_o` = bits [20:16], `result_o` = effective address.
- R5: Opcode 32 (byte load): as R4 but `mem_byte_o`=1.
- R6: Opcode 43 (word store): `mem_wr_o`=1, `mem_rd_o`=0, `mem_byte_o`=0, `reg_we_o`=0, `wr_idx_o`=0, `result_o` = effective address; the rt value does not reach the result.
- R7: Opcode 40 (byte store): as R6 but `mem_byte_o`=1.
- R8: The effective address is the rs value plus bits [15:0] sign-extended to 32 bits, so an offset with bit 15 set subtracts, wrapping modulo 2^32.
- R9: Any other opcode, or opcode 0 with any other function code, sets `illegal_o`=1 with `reg_we_o`, `mem_rd_o`, `mem_wr_o`, `mem_byte_o` all 0, `wr_idx_o`=0 and `result_o`=0.
- R10: Opcode 0 with a legal function code but a nonzero shift field is illegal and behaves as R9.
- R11: The two memory strobes are never high together, and a store never has `reg_we_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | DATA_W | Value of the register named by bits [25:21] |
| rt_val_i | input | DATA_W | Value of the register named by bits [20:16] |
| rs_idx_o | output | 5 | First source register index |
| rt_idx_o | output | 5 | Second source register index |
| wr_idx_o | output | 5 | Destination register index, 0 when nothing is written |
| reg_we_o | output | 1 | Register write enable |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_byte_o | output | 1 | Access size: 1 byte, 0 word |
| result_o | output | DATA_W | Arithmetic result or effective address |
| illegal_o | output | 1 | Encoding is outside the supported subset |

## Verification
The bench goes after sum and difference wrap-around, where a design that widened or saturated would give the wrong value, and after negative offsets, where a zero-extended offset would produce an address 64 KiB too high. It checks that stores take their destination field as data rather than as a write target, catching a design that writes rt on a store, and that the byte loads and stores carry the size flag that a decoder confusing opcodes 32 and 40 with 35 and 43 would drop. It also feeds neighbouring function codes, a nonzero shift field and an unrelated opcode, where a loose decoder would raise a strobe or a write enable.

// File: rtl/subset_exec_pkg.sv
package subset_exec_pkg;

  localparam int INSTR_W  = 32;
  localparam int OPC_W    = 6;
  localparam int FUNCT_W  = 6;
  localparam int REGIX_W  = 5;
  localparam int SHIFT_W  = 5;
  localparam int IMM_W    = 16;

  // Bit positions of the instruction fields (high end of each field).
  localparam int OPC_HI   = 31;
  localparam int RS_HI    = 25;
  localparam int RT_HI    = 20;
  localparam int RD_HI    = 15;
  localparam int SHIFT_HI = 10;
  localparam int FUNCT_HI = 5;

  localparam logic [OPC_W-1:0]   OPC_REG    = 6'd0;
  localparam logic [OPC_W-1:0]   OPC_LDW    = 6'd35;
  localparam logic [OPC_W-1:0]   OPC_STW    = 6'd43;
  localparam logic [OPC_W-1:0]   OPC_LDB    = 6'd32;
  localparam logic [OPC_W-1:0]   OPC_STB    = 6'd40;
  localparam logic [FUNCT_W-1:0] FN_SUM     = 6'd32;
  localparam logic [FUNCT_W-1:0] FN_DIFF    = 6'd34;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_RD   = 2'd1,
    DST_RT   = 2'd2
  } dst_sel_e;

  typedef struct packed {
    logic     reg_we;
    logic     mem_rd;
    logic     mem_wr;
    logic     mem_byte;
    logic     use_imm;
    logic     negate;
    dst_sel_e dst_sel;
    logic     illegal;
  } ctrl_t;

endpackage

// File: rtl/subset_field_split.sv
module subset_field_split
  import subset_exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic [OPC_W-1:0]   opc_o,
  output logic [REGIX_W-1:0] rs_o,
  output logic [REGIX_W-1:0] rt_o,
  output logic [REGIX_W-1:0] rd_o,
  output logic [SHIFT_W-1:0] shift_o,
  output logic [FUNCT_W-1:0] funct_o,
  output logic [DATA_W-1:0]  imm_ext_o
);

  localparam int EXT_W = DATA_W - IMM_W;

  assign opc_o   = instr_i[OPC_HI   -: OPC_W];
  assign rs_o    = instr_i[RS_HI    -: REGIX_W];
  assign rt_o    = instr_i[RT_HI    -: REGIX_W];
  assign rd_o    = instr_i[RD_HI    -: REGIX_W];
  assign shift_o = instr_i[SHIFT_HI -: SHIFT_W];
  assign funct_o = instr_i[FUNCT_HI -: FUNCT_W];

  generate
    if (EXT_W > 0) begin : g_sext
      assign imm_ext_o = {{EXT_W{instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};
    end else begin : g_trunc
      assign imm_ext_o = instr_i[DATA_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/subset_decoder.sv
module subset_decoder
  import subset_exec_pkg::*;
(
  input  logic [OPC_W-1:0]   opc_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output ctrl_t              ctrl_o
);

  always_comb begin
    ctrl_o = '{reg_we: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0, mem_byte: 1'b0,
               use_imm: 1'b0, negate: 1'b0, dst_sel: DST_NONE, illegal: 1'b1};
    unique case (opc_i)
      OPC_REG: begin
        if (shift_i == '0 && (funct_i == FN_SUM || funct_i == FN_DIFF)) begin
          ctrl_o.illegal = 1'b0;
          ctrl_o.reg_we  = 1'b1;
          ctrl_o.dst_sel = DST_RD;
          ctrl_o.negate  = (funct_i == FN_DIFF);
        end
      end
      OPC_LDW, OPC_LDB: begin
        ctrl_o.illegal  = 1'b0;
        ctrl_o.reg_we   = 1'b1;
        ctrl_o.mem_rd   = 1'b1;
        ctrl_o.use_imm  = 1'b1;
        ctrl_o.dst_sel  = DST_RT;
        ctrl_o.mem_byte = (opc_i == OPC_LDB);
      end
      OPC_STW, OPC_STB: begin
        ctrl_o.illegal  = 1'b0;
        ctrl_o.mem_wr   = 1'b1;
        ctrl_o.use_imm  = 1'b1;
        ctrl_o.mem_byte = (opc_i == OPC_STB);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/subset_adder.sv
module subset_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              negate_i,
  output logic [DATA_W-1:0] sum_o
);

  logic [DATA_W-1:0] b_eff;

  // Subtraction as a + ~b + 1; the carry out is dropped, so both wrap.
  assign b_eff = b_i ^ {DATA_W{negate_i}};
  assign sum_o = a_i + b_eff + {{(DATA_W-1){1'b0}}, negate_i};

endmodule

// File: rtl/subset_exec_unit.sv
module subset_exec_unit
  import subset_exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  rs_val_i,
  input  logic [DATA_W-1:0]  rt_val_i,
  output logic [REGIX_W-1:0] rs_idx_o,
  output logic [REGIX_W-1:0] rt_idx_o,
  output logic [REGIX_W-1:0] wr_idx_o,
  output logic               reg_we_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic               mem_byte_o,
  output logic [DATA_W-1:0]  result_o,
  output logic               illegal_o
);

  logic [OPC_W-1:0]   opc;
  logic [REGIX_W-1:0] rd;
  logic [SHIFT_W-1:0] shift;
  logic [FUNCT_W-1:0] funct;
  logic [DATA_W-1:0]  imm_ext;
  logic [DATA_W-1:0]  opb;
  logic [DATA_W-1:0]  sum;
  ctrl_t              ctrl;

  subset_field_split #(.DATA_W(DATA_W)) u_split (
    .instr_i   (instr_i),
    .opc_o     (opc),
    .rs_o      (rs_idx_o),
    .rt_o      (rt_idx_o),
    .rd_o      (rd),
    .shift_o   (shift),
    .funct_o   (funct),
    .imm_ext_o (imm_ext)
  );

  subset_decoder u_dec (
    .opc_i   (opc),
    .shift_i (shift),
    .funct_i (funct),
    .ctrl_o  (ctrl)
  );

  assign opb = ctrl.use_imm ? imm_ext : rt_val_i;

  subset_adder #(.DATA_W(DATA_W)) u_add (
    .a_i      (rs_val_i),
    .b_i      (opb),
    .negate_i (ctrl.negate),
    .sum_o    (sum)
  );

  always_comb begin
    unique case (ctrl.dst_sel)
      DST_RD:  wr_idx_o = rd;
      DST_RT:  wr_idx_o = rt_idx_o;
      default: wr_idx_o = '0;
    endcase
  end

  assign reg_we_o   = ctrl.reg_we;
  assign mem_rd_o   = ctrl.mem_rd;
  assign mem_wr_o   = ctrl.mem_wr;
  assign mem_byte_o = ctrl.mem_byte;
  assign illegal_o  = ctrl.illegal;
  assign result_o   = ctrl.illegal ? '0 : sum;

endmodule

// File: rtl/subset_exec_unit_chk.sv
module subset_exec_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic [31:0]       instr_i,
  input logic [DATA_W-1:0] rs_val_i,
  input logic [4:0]        rt_idx_o,
  input logic [4:0]        wr_idx_o,
  input logic              reg_we_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic              mem_byte_o,
  input logic [DATA_W-1:0] result_o,
  input logic              illegal_o
);

  logic [DATA_W-1:0] addr_ref;
  assign addr_ref = rs_val_i + {{(DATA_W-16){instr_i[15]}}, instr_i[15:0]};

  always_comb begin
    a_r9_illegal_quiet: assert (!illegal_o ||
      (!reg_we_o && !mem_rd_o && !mem_wr_o && !mem_byte_o && wr_idx_o == '0))
      else $error("illegal encoding left a strobe or write enabled");
    a_r11_one_strobe: assert ($onehot0({mem_rd_o, mem_wr_o}))
      else $error("read and write strobes both high");
    a_r6_store_no_write: assert (!mem_wr_o || !reg_we_o)
      else $error("store enabled a register write");
    a_r4_load_dest: assert (!mem_rd_o || (reg_we_o && wr_idx_o == rt_idx_o))
      else $error("load does not target rt");
    a_r8_addr: assert (!(mem_rd_o || mem_wr_o) || result_o == addr_ref)
      else $error("effective address mismatch");
    a_r2_rtype_dest: assert (illegal_o || instr_i[31:26] != 6'd0 ||
      (reg_we_o && wr_idx_o == instr_i[15:11]))
      else $error("register-format destination mismatch");
  end

endmodule

bind subset_exec_unit subset_exec_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .instr_i    (instr_i),
  .rs_val_i   (rs_val_i),
  .rt_idx_o   (rt_idx_o),
  .wr_idx_o   (wr_idx_o),
  .reg_we_o   (reg_we_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .mem_byte_o (mem_byte_o),
  .result_o   (result_o),
  .illegal_o  (illegal_o)
);

// File: tb/tb_subset_exec_unit.sv
module tb_subset_exec_unit;

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic [4:0]  widx;
    logic        we;
    logic        rd;
    logic        wr;
    logic        byt;
    logic        ill;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    // R2 add $8,$17,$18
    '{32'h02324020, 32'd5,        32'd7,        32'd12,       5'd8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    // R2 add wrap
    '{32'h02324020, 32'hFFFFFFFF, 32'd2,        32'd1,        5'd8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    // R3 sub $8,$8,$18 negative result
    '{32'h01124022, 32'd3,        32'd5,        32'hFFFFFFFE, 5'd8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    // R3 sub wrap
    '{32'h01124022, 32'h80000000, 32'd1,        32'h7FFFFFFF, 5'd8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    // R4 lw $8,8($19)
    '{32'h8E680008, 32'h00001000, 32'hDEADBEEF, 32'h00001008, 5'd8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    // R6 sw $8,32($19)
    '{32'hAE680020, 32'h00001000, 32'hDEADBEEF, 32'h00001020, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    // R5 lb $8,1($19)
    '{32'h82680001, 32'd0,        32'hDEADBEEF, 32'd1,        5'd8, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    // R7 sb $8,6($19)
    '{32'hA2680006, 32'd0,        32'hDEADBEEF, 32'd6,        5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    // R8 lw $8,-4($18)
    '{32'h8E48FFFC, 32'h00000100, 32'd0,        32'h000000FC, 5'd8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    // R8 negative offset wraps below zero
    '{32'h8E48FFFC, 32'd0,        32'd0,        32'hFFFFFFFC, 5'd8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    // R9 opcode 2
    '{32'h08000000, 32'd5,        32'd7,        32'd0,        5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    // R9 opcode 0 funct 33
    '{32'h02324021, 32'd5,        32'd7,        32'd0,        5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    // R10 add with shift field 5
    '{32'h02324160, 32'd5,        32'd7,        32'd0,        5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1:   return "R2";
      2, 3:   return "R3";
      4:      return "R4";
      5:      return "R6";
      6:      return "R5";
      7:      return "R7";
      8, 9:   return "R8";
      10, 11: return "R9";
      default: return "R10";
    endcase
  endfunction

  logic        clk;
  logic [31:0] instr;
  logic [31:0] rs_val;
  logic [31:0] rt_val;
  logic [4:0]  rs_idx, rt_idx, wr_idx;
  logic        reg_we, mem_rd, mem_wr, mem_byte, illegal;
  logic [31:0] result;

  int n_run  = 0;
  int n_fail = 0;

  subset_exec_unit dut (
    .instr_i    (instr),
    .rs_val_i   (rs_val),
    .rt_val_i   (rt_val),
    .rs_idx_o   (rs_idx),
    .rt_idx_o   (rt_idx),
    .wr_idx_o   (wr_idx),
    .reg_we_o   (reg_we),
    .mem_rd_o   (mem_rd),
    .mem_wr_o   (mem_wr),
    .mem_byte_o (mem_byte),
    .result_o   (result),
    .illegal_o  (illegal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    instr  = i;
    rs_val = a;
    rt_val = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    instr = '0; rs_val = '0; rt_val = '0;

    // All-zero word: opcode 0, funct 0, not in the subset.
    apply(32'h0, 32'd9, 32'd9);
    check("R9", "zero word illegal", {31'd0, illegal}, 32'd1);
    check("R9", "zero word we", {31'd0, reg_we}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].instr, VECS[i].a, VECS[i].b);
      check(tag_of(i), "result", result, VECS[i].res);
      check(tag_of(i), "wr_idx", {27'd0, wr_idx}, {27'd0, VECS[i].widx});
      check(tag_of(i), "strobes",
            {27'd0, reg_we, mem_rd, mem_wr, mem_byte, illegal},
            {27'd0, VECS[i].we, VECS[i].rd, VECS[i].wr, VECS[i].byt, VECS[i].ill});
    end

    // R1: source fields come out for legal and illegal words alike.
    apply(32'h02324020, 32'd0, 32'd0);
    check("R1", "rs_idx add", {27'd0, rs_idx}, 32'd17);
    check("R1", "rt_idx add", {27'd0, rt_idx}, 32'd18);
    apply(32'h0FFF0000, 32'd0, 32'd0);
    check("R1", "rs_idx illegal", {27'd0, rs_idx}, 32'd31);
    check("R1", "rt_idx illegal", {27'd0, rt_idx}, 32'd31);

    // R6: store ignores the rt value entirely.
    apply(32'hAE680020, 32'h00001000, 32'h00000000);
    check("R6", "store result rt=0", result, 32'h00001020);
    apply(32'hAE680020, 32'h00001000, 32'hFFFFFFFF);
    check("R6", "store result rt=ones", result, 32'h00001020);

    // R11: no encoding raises both strobes or a write on a store.
    for (int op = 0; op < 64; op++) begin
      apply({op[5:0], 26'h0324020}, 32'd1, 32'd1);
      check("R11", "strobe exclusivity",
            {30'd0, mem_rd & mem_wr, mem_wr & reg_we}, 32'd0);
    end

    // R3 subtract to zero, R8 largest negative offset
    apply(32'h01124022, 32'h12345678, 32'h12345678);
    check("R3", "sub equal", result, 32'd0);
    apply(32'hA2688000, 32'h00010000, 32'd0);
    check("R8", "offset -32768", result, 32'h00008000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule